// File: doc/BRIEF.md
# Mantissa-exponent gain applicator

This block applies one programmable gain to the in-phase and quadrature lanes of a complex baseband sample stream. Each input lane is a 10-bit fractional two's complement value with one integer (sign) bit and nine fraction bits. The gain is the product of a mantissa between 1.0 and 1 + 63/64, in steps of 1/64, and a left shift by 0 to 15 bit positions. Each scaled lane is rounded half-up and then clamped into an 8-bit fractional two's complement word with seven fraction bits. That word feeds the detection stages that follow.

The gain comes from a level-control loop outside this block. It arrives as a 6-bit mantissa fraction and a 4-bit shift count, loaded by a write strobe. The loaded gain applies to every sample accepted after the write cycle, so a gain change always falls on a sample boundary. Samples stream in with a valid flag and come out with a valid flag two cycles later.

Top module: `ga_gain_apply`

## Requirements
- R1: `out_vld` is high exactly two clock cycles after a cycle in which `in_vld` is high, and low otherwise; back-to-back samples produce back-to-back outputs.
- R2: For an input code x, mantissa field M and shift field E, the output code is floor((x * (64 + M) * 2^E + 128) / 256). This is round-half-up on the eight discarded bits: code 2 at unity gain gives 1, and code -2 gives 0.
- R3: When the rounded result exceeds the 8-bit range, the output is 127 for positive overflow and -128 for negative overflow, never a wrapped value (code 511 at unity gain gives 127).
- R4: A gain written with `gain_wr` high in cycle t applies to samples accepted in cycles after t. A sample accepted in cycle t itself still uses the previous gain, and the gain holds while `gain_wr` is low.
- R5: The I and Q lanes use the same gain at all times and are computed independently from their own inputs.
- R6: After reset `out_vld` is 0, both output words are 0, and the gain is unity (M = 0, E = 0).
- R7: While no new result is produced, `out_i` and `out_q` hold the last result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gain_wr | input | 1 | Load strobe for the gain fields |
| gain_man | input | 6 | Mantissa fraction M, gain mantissa is 1 + M/64 |
| gain_exp | input | 4 | Shift count E, gain multiplied by 2^E |
| in_vld | input | 1 | Input sample valid |
| in_i | input | 10 | In-phase sample, fractional two's complement |
| in_q | input | 10 | Quadrature sample, fractional two's complement |
| out_vld | output | 1 | Output sample valid |
| out_i | output | 8 | Scaled in-phase result |
| out_q | output | 8 | Scaled quadrature result |

## Verification
The assertions check several properties on every cycle. A valid output always traces back to a valid input two cycles earlier. Any product beyond the rounding threshold of either rail lands on that rail. A zero input gives a zero product. The gain and the lane outputs stay stable when no write or no new result is present. Only the bench's scenarios show the exact rounded values across many mantissa and shift settings and the half-code tie cases. They also show that a gain written in the same cycle as a sample misses that sample, and that the two lanes stay independent.

// File: rtl/ga_pkg.sv
package ga_pkg;
  localparam int GA_MAN_W = 6;
  localparam int GA_EXP_W = 4;

  typedef struct packed {
    logic [GA_MAN_W-1:0] man;
    logic [GA_EXP_W-1:0] shift;
  } ga_gain_t;
endpackage

// File: rtl/ga_gain_reg.sv
module ga_gain_reg
  import ga_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr,
  input  logic [GA_MAN_W-1:0] man,
  input  logic [GA_EXP_W-1:0] shift,
  output ga_gain_t            gain_q
);
  ga_gain_t gain_d;

  always_comb begin
    gain_d = gain_q;
    if (wr) begin
      gain_d.man   = man;
      gain_d.shift = shift;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gain_q <= '0;
    else        gain_q <= gain_d;
  end

  AST_GAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(gain_q)); // R4
endmodule

// File: rtl/ga_lane_scale.sv
module ga_lane_scale
  import ga_pkg::*;
#(
  parameter int IN_W   = 10,
  parameter int PROD_W = 33
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic signed [IN_W-1:0]   x,
  input  ga_gain_t                 gain,
  output logic signed [PROD_W-1:0] prod_q
);
  logic signed [PROD_W-1:0] x_ext;
  logic signed [PROD_W-1:0] mant;
  logic signed [PROD_W-1:0] prod_d;

  always_comb begin
    x_ext  = {{(PROD_W-IN_W){x[IN_W-1]}}, x};
    mant   = {{(PROD_W-GA_MAN_W-1){1'b0}}, 1'b1, gain.man};
    prod_d = prod_q;
    if (en) prod_d = (x_ext * mant) <<< gain.shift;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prod_q <= '0;
    else        prod_q <= prod_d;
  end

  AST_ZERO_PRODUCT: assert property (@(posedge clk) disable iff (!rst_n)
    (en && x == '0) |=> (prod_q == '0)); // R2
endmodule

// File: rtl/ga_round_sat.sv
module ga_round_sat #(
  parameter int PROD_W = 33,
  parameter int DROP   = 8,
  parameter int OUT_W  = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic signed [PROD_W-1:0] prod,
  output logic signed [OUT_W-1:0]  y_q
);
  localparam int SW = PROD_W + 1;
  localparam logic signed [SW-1:0] HALF  = SW'(1) <<< (DROP - 1);
  localparam logic signed [SW-1:0] MAXV  = (SW'(1) <<< (OUT_W - 1)) - SW'(1);
  localparam logic signed [SW-1:0] MINV  = -(SW'(1) <<< (OUT_W - 1));
  localparam logic signed [SW-1:0] THR_HI = (MAXV <<< DROP) + HALF;
  localparam logic signed [SW-1:0] THR_LO = (MINV <<< DROP) - HALF;

  logic signed [SW-1:0]    sum;
  logic signed [SW-1:0]    shifted;
  logic signed [OUT_W-1:0] y_d;

  always_comb begin
    sum     = {prod[PROD_W-1], prod} + HALF;
    shifted = sum >>> DROP;
    y_d     = y_q;
    if (en) begin
      if (shifted > MAXV)      y_d = MAXV[OUT_W-1:0];
      else if (shifted < MINV) y_d = MINV[OUT_W-1:0];
      else                     y_d = shifted[OUT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) y_q <= '0;
    else        y_q <= y_d;
  end

  AST_SAT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $signed({prod[PROD_W-1], prod}) >= THR_HI) |=> (y_q == MAXV[OUT_W-1:0])); // R3
  AST_SAT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $signed({prod[PROD_W-1], prod}) < THR_LO) |=> (y_q == MINV[OUT_W-1:0])); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(y_q)); // R7
endmodule

// File: rtl/ga_gain_apply.sv
module ga_gain_apply
  import ga_pkg::*;
#(
  parameter int IN_W  = 10,
  parameter int OUT_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       gain_wr,
  input  logic [GA_MAN_W-1:0]        gain_man,
  input  logic [GA_EXP_W-1:0]        gain_exp,
  input  logic                       in_vld,
  input  logic signed [IN_W-1:0]     in_i,
  input  logic signed [IN_W-1:0]     in_q,
  output logic                       out_vld,
  output logic signed [OUT_W-1:0]    out_i,
  output logic signed [OUT_W-1:0]    out_q
);
  localparam int LANES  = 2;
  localparam int PROD_W = IN_W + GA_MAN_W + 2 + (2**GA_EXP_W - 1);
  localparam int DROP   = (IN_W - 1) + GA_MAN_W - (OUT_W - 1);

  ga_gain_t gain_q;
  logic     vld_mid_q, vld_out_q;
  logic     vld_mid_d, vld_out_d;

  logic signed [IN_W-1:0]   lane_in  [LANES];
  logic signed [PROD_W-1:0] lane_mid [LANES];
  logic signed [OUT_W-1:0]  lane_out [LANES];

  assign lane_in[0] = in_i;
  assign lane_in[1] = in_q;

  ga_gain_reg u_gain (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (gain_wr),
    .man    (gain_man),
    .shift  (gain_exp),
    .gain_q (gain_q)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    ga_lane_scale #(.IN_W(IN_W), .PROD_W(PROD_W)) u_scale (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (in_vld),
      .x      (lane_in[g]),
      .gain   (gain_q),
      .prod_q (lane_mid[g])
    );
    ga_round_sat #(.PROD_W(PROD_W), .DROP(DROP), .OUT_W(OUT_W)) u_rsat (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (vld_mid_q),
      .prod  (lane_mid[g]),
      .y_q   (lane_out[g])
    );
  end

  always_comb begin
    vld_mid_d = in_vld;
    vld_out_d = vld_mid_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_mid_q <= 1'b0;
      vld_out_q <= 1'b0;
    end else begin
      vld_mid_q <= vld_mid_d;
      vld_out_q <= vld_out_d;
    end
  end

  assign out_vld = vld_out_q;
  assign out_i   = lane_out[0];
  assign out_q   = lane_out[1];

  AST_VLD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> $past(in_vld, 2)); // R1
endmodule

// File: tb/ga_gain_apply_tb.sv
`timescale 1ns/1ps
module ga_gain_apply_tb;
  logic clk = 1'b0;
  logic rst_n;
  logic gain_wr;
  logic [5:0] gain_man;
  logic [3:0] gain_exp;
  logic in_vld;
  logic signed [9:0] in_i, in_q;
  logic out_vld;
  logic signed [7:0] out_i, out_q;

  int n_chk = 0;
  int n_fail = 0;
  string cur_req = "R6";
  bit done = 0;

  always #2.5 clk = ~clk;

  ga_gain_apply u_dut (
    .clk(clk), .rst_n(rst_n), .gain_wr(gain_wr), .gain_man(gain_man),
    .gain_exp(gain_exp), .in_vld(in_vld), .in_i(in_i), .in_q(in_q),
    .out_vld(out_vld), .out_i(out_i), .out_q(out_q)
  );

  function automatic int ref_scale(int x, int m, int e);
    longint p;
    longint r;
    p = longint'(x) * longint'(64 + m) * (longint'(1) << e);
    r = (p + 128) >>> 8;
    if (r > 127) r = 127;
    if (r < -128) r = -128;
    return int'(r);
  endfunction

  // behavioural reference: gain model plus a two-entry delay line
  int m_man, m_exp;
  bit v1, v2;
  int e1i, e1q, e2i, e2q;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_man = 0; m_exp = 0; v1 = 0; v2 = 0;
      e1i = 0; e1q = 0; e2i = 0; e2q = 0;
    end else begin
      v2 = v1;
      if (v1) begin e2i = e1i; e2q = e1q; end
      v1 = in_vld;
      if (in_vld) begin
        e1i = ref_scale(int'(in_i), m_man, m_exp);
        e1q = ref_scale(int'(in_q), m_man, m_exp);
      end
      if (gain_wr) begin m_man = int'(gain_man); m_exp = int'(gain_exp); end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_chk++;
      if (out_vld !== v2 || int'(out_i) != e2i || int'(out_q) != e2q) begin
        n_fail++;
        $display("FAIL %s vld=%0b i=%0d q=%0d expected vld=%0b i=%0d q=%0d",
                 cur_req, out_vld, out_i, out_q, v2, e2i, e2q);
      end
    end
  end

  task automatic idle(int n);
    in_vld = 0; gain_wr = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic send(int i, int q);
    in_vld = 1; in_i = 10'(i); in_q = 10'(q); gain_wr = 0;
    @(negedge clk);
    in_vld = 0;
  endtask

  task automatic set_gain(int m, int e);
    gain_wr = 1; gain_man = 6'(m); gain_exp = 4'(e); in_vld = 0;
    @(negedge clk);
    gain_wr = 0;
  endtask

  int vals [8] = '{2, -2, 6, -6, 511, -512, 37, -200};
  int mans [4] = '{0, 1, 32, 63};
  int exps [3] = '{0, 1, 3};

  initial begin
    rst_n = 0; gain_wr = 0; gain_man = 0; gain_exp = 0;
    in_vld = 0; in_i = 0; in_q = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    // R6: reset state and unity gain
    cur_req = "R6";
    n_chk++;
    if (out_vld !== 1'b0 || out_i !== 8'sd0 || out_q !== 8'sd0) begin
      n_fail++;
      $display("FAIL R6 vld=%0b i=%0d q=%0d expected 0 0 0", out_vld, out_i, out_q);
    end
    idle(3);
    send(2, -2); send(100, -100); idle(3);
    // R2: rounding across mantissa and shift settings
    cur_req = "R2";
    foreach (mans[a]) foreach (exps[b]) begin
      set_gain(mans[a], exps[b]);
      for (int k = 0; k < 8; k++) send(vals[k], vals[7-k]);
      idle(2);
    end
    // R3: saturation at both rails
    cur_req = "R3";
    set_gain(0, 15); send(1, -1); send(511, -512); send(0, 0); idle(3);
    set_gain(63, 8); send(3, -3); send(-1, 1); idle(3);
    set_gain(0, 0); send(511, -512); idle(3);
    // R4: gain written in the same cycle as a sample
    cur_req = "R4";
    set_gain(0, 0);
    gain_wr = 1; gain_man = 6'd63; gain_exp = 4'd2;
    in_vld = 1; in_i = 10'sd40; in_q = -10'sd40;
    @(negedge clk);
    gain_wr = 0;
    send(40, -40); idle(4); send(40, -40); idle(3);
    // R5: independent lanes, shared gain
    cur_req = "R5";
    set_gain(17, 1); send(300, -7); send(-7, 300); send(0, 255); idle(3);
    // R7: hold between results
    cur_req = "R7";
    send(120, -33); idle(5); send(-9, 9); idle(5);
    // R1: back-to-back stream
    cur_req = "R1";
    set_gain(5, 2);
    for (int k = 0; k < 20; k++) send(k * 23 - 230, 200 - k * 19);
    idle(4);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired in %s", cur_req);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule